// File: doc/BRIEF.md
# Machine Cycle Sequencer

This block produces the clock-by-clock bus activity of one instruction for a small 8-bit processor. A controller hands it a list of up to five machine cycles with a 16-bit address and a write byte for each entry, then pulses `start`. The block steps through the list in order. Each clock is one T-state. It drives a shared low bus that carries the low address byte in the first T-state and data afterwards, plus a high address byte, an address latch strobe, a three-bit cycle status code and active-low read and write strobes.

Bytes read from the bus are captured and presented with a one-clock valid flag. When the last T-state of the last cycle ends, the block pulses `done` and shows the total number of T-states the instruction used. A two-cycle load-immediate instruction therefore reports 7. A fetch, operand read and port write instruction reports 10.

Top module: `mcyc_seq`

## Requirements
- R1: After reset, and whenever no instruction is in progress, the outputs are `ale`=0, `io_m`=`s1`=`s0`=0, `rd_n`=`wr_n`=1, `ad_oe`=0, `a_hi`=0, `busy`=0, `done`=0 and `rd_valid`=0.
- R2: An opcode fetch lasts four T-states and every other cycle type lasts three. Each T-state is one clock. T1 of the first cycle starts on the clock after the edge that samples `start`, and the cycles follow each other with no idle clock between them.
- R3: The kind field per list entry is coded 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, and codes 5 to 7 act as memory read. The status {`io_m`,`s1`,`s0`} is held for the whole cycle as 011 for fetch, 010 for memory read, 001 for memory write, 110 for I/O read and 101 for I/O write.
- R4: `ale` is high in T1 of every cycle and low in all other T-states.
- R5: In T1, `ad_oe`=1 and `ad_out` carries address bits 7:0. In T2 and T3 of write cycles, `ad_oe`=1 and `ad_out` carries the entry's write byte. In every other T-state `ad_oe`=0.
- R6: `rd_n` is low in T2 and T3 of fetch, memory read and I/O read cycles. `wr_n` is low in T2 and T3 of memory write and I/O write cycles. Both strobes are high at all other times.
- R7: In memory cycles `a_hi` carries address bits 15:8. In I/O cycles `a_hi` repeats the 8-bit port address (address bits 7:0), which is also the T1 value of `ad_out`.
- R8: In read-type cycles, `ad_in` is sampled at the clock edge that ends T3. The byte appears on `rdata` with `rd_valid` high for exactly the following clock.
- R9: List entries run from index 0 upward. Entry 0 always runs as an opcode fetch whatever its kind field. `n_cyc`=0 runs one cycle, and values above five run five.
- R10: `done` is high for one clock, the clock after the last T-state. At that point `t_total` equals 4 + 3·(cycles − 1), and it holds that value until the next accepted `start`.
- R11: A `start` pulse while `busy` is high is ignored. The list, the cycle order and the timing of the running instruction do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, one T-state per period |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | loads the list and begins an instruction when idle |
| n_cyc | input | 3 | number of machine cycles in the list |
| kind_list | input | 15 | 3-bit cycle kind per entry, entry i at bits 3i+2:3i |
| addr_list | input | 80 | 16-bit address per entry, entry i at bits 16i+15:16i |
| wdata_list | input | 40 | write byte per entry, entry i at bits 8i+7:8i |
| ad_in | input | 8 | data read from the shared low bus |
| ad_out | output | 8 | value driven on the shared low bus |
| ad_oe | output | 1 | drive enable for the shared low bus |
| a_hi | output | 8 | high address byte |
| ale | output | 1 | address latch strobe |
| io_m | output | 1 | status: I/O (1) or memory (0) |
| s1 | output | 1 | status bit 1 |
| s0 | output | 1 | status bit 0 |
| rd_n | output | 1 | active-low read strobe |
| wr_n | output | 1 | active-low write strobe |
| rdata | output | 8 | last captured read byte |
| rd_valid | output | 1 | one-clock flag for a new `rdata` |
| busy | output | 1 | instruction in progress |
| done | output | 1 | one-clock end-of-instruction pulse |
| t_total | output | 5 | T-states used by the last instruction |

## Verification
A T-state counter that slips by one shows within a single clock. The strobe windows, `ale` or the bus direction move away from their expected T-state, and every later cycle of the same instruction is shifted as well. A wrong cycle index or a lost latched list shows at the next T1 as a wrong status code or a wrong address byte. A wrong cycle-length decision shows as a missing or extra fourth T-state, and then as a `t_total` value at the `done` pulse that differs from 4 + 3·(n − 1). Capture at the wrong edge shows on the clock after T3, because the bench changes `ad_in` only during T3.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   typedef enum logic [2:0] {
      MC_OPF  = 3'd0,
      MC_MRD  = 3'd1,
      MC_MWR  = 3'd2,
      MC_IORD = 3'd3,
      MC_IOWR = 3'd4
   } mc_kind_e;

   typedef struct packed {
      logic io_m;
      logic s1;
      logic s0;
   } mc_stat_t;

   // unused codes fall back to a plain memory read
   function automatic mc_kind_e norm_kind(input logic [2:0] raw);
      if (raw > 3'd4) return MC_MRD;
      return mc_kind_e'(raw);
   endfunction

   function automatic mc_stat_t stat_of(input mc_kind_e k);
      mc_stat_t s;
      case (k)
         MC_OPF:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
         MC_MWR:  s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
         MC_IORD: s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
         MC_IOWR: s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
         default: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      endcase
      return s;
   endfunction

   function automatic logic is_read(input mc_kind_e k);
      return (k == MC_OPF) || (k == MC_MRD) || (k == MC_IORD);
   endfunction

   function automatic logic is_write(input mc_kind_e k);
      return (k == MC_MWR) || (k == MC_IOWR);
   endfunction

   function automatic logic is_io(input mc_kind_e k);
      return (k == MC_IORD) || (k == MC_IOWR);
   endfunction

   // index of the final T-state: fetch has four, the rest three
   function automatic logic [1:0] last_t(input mc_kind_e k);
      return (k == MC_OPF) ? 2'd3 : 2'd2;
   endfunction

endpackage

// File: rtl/mcyc_tstate_ctr.sv
module mcyc_tstate_ctr
   import mcyc_pkg::*;
#(
   parameter int MAX_CYC = 5,
   parameter int NCW     = 3,
   parameter int TW      = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [NCW-1:0] n_cyc,
   input  mc_kind_e       cur_kind,
   output logic           load,
   output logic           busy,
   output logic [NCW-1:0] idx,
   output logic [1:0]     tst,
   output logic           done,
   output logic [TW-1:0]  t_total
);

   logic [NCW-1:0] last_idx;
   logic [NCW-1:0] last_idx_d;
   logic           end_of_cyc;
   logic           end_of_instr;

   assign load = start && !busy;

   always_comb begin
      if (n_cyc == '0)
         last_idx_d = '0;
      else if (n_cyc > NCW'(MAX_CYC))
         last_idx_d = NCW'(MAX_CYC - 1);
      else
         last_idx_d = n_cyc - 1'b1;
   end

   assign end_of_cyc   = busy && (tst == last_t(cur_kind));
   assign end_of_instr = end_of_cyc && (idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         idx      <= '0;
         tst      <= 2'd0;
         last_idx <= '0;
         done     <= 1'b0;
         t_total  <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy     <= 1'b1;
            idx      <= '0;
            tst      <= 2'd0;
            last_idx <= last_idx_d;
            t_total  <= '0;
         end else if (busy) begin
            t_total <= t_total + 1'b1;
            if (end_of_cyc) begin
               tst <= 2'd0;
               if (end_of_instr) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end else begin
               tst <= tst + 1'b1;
            end
         end
      end
   end

   // R2
   tst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tst <= last_t(cur_kind)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !end_of_instr) |=> (busy && $stable(last_idx)));

endmodule

// File: rtl/mcyc_bus_drv.sv
module mcyc_bus_drv
   import mcyc_pkg::*;
#(
   parameter int AW             = 16,
   parameter int DW             = 8,
   parameter bit IO_ADDR_MIRROR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [1:0]       tst,
   input  mc_kind_e         kind,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    ad_out,
   output logic             ad_oe,
   output logic [AW-DW-1:0] a_hi,
   output logic             ale,
   output logic             io_m,
   output logic             s1,
   output logic             s0,
   output logic             rd_n,
   output logic             wr_n
);

   localparam int HW = AW - DW;

   logic [HW-1:0] hi_io;
   logic          t_first;
   logic          t_strobe;
   mc_stat_t      st;

   generate
      if (IO_ADDR_MIRROR) begin : g_mirror
         assign hi_io = addr[HW-1:0];
      end else begin : g_nomirror
         assign hi_io = '0;
      end
   endgenerate

   assign t_first  = busy && (tst == 2'd0);
   assign t_strobe = busy && ((tst == 2'd1) || (tst == 2'd2));
   assign st       = stat_of(kind);

   always_comb begin
      ale    = t_first;
      io_m   = busy ? st.io_m : 1'b0;
      s1     = busy ? st.s1   : 1'b0;
      s0     = busy ? st.s0   : 1'b0;
      rd_n   = !(t_strobe && is_read(kind));
      wr_n   = !(t_strobe && is_write(kind));
      ad_oe  = t_first || (t_strobe && is_write(kind));
      ad_out = t_first ? addr[DW-1:0] : wdata;
      if (!busy)
         a_hi = '0;
      else if (is_io(kind))
         a_hi = hi_io;
      else
         a_hi = addr[AW-1:DW];
   end

   // R4
   ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R5
   ale_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> ad_oe);

   // R6
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R6
   rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |=> !rd_n);

endmodule

// File: rtl/mcyc_rd_capture.sv
module mcyc_rd_capture
   import mcyc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic [1:0]    tst,
   input  mc_kind_e      kind,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] rdata,
   output logic          rd_valid
);

   logic take;

   assign take = busy && (tst == 2'd2) && is_read(kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= take;
         if (take) rdata <= ad_in;
      end
   end

   // R8
   rv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int  MAX_CYC        = 5,
   parameter int  AW             = 16,
   parameter int  DW             = 8,
   parameter bit  IO_ADDR_MIRROR = 1'b1,
   localparam int NCW            = $clog2(MAX_CYC + 1),
   localparam int TW             = $clog2(4 * MAX_CYC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [NCW-1:0]        n_cyc,
   input  logic [3*MAX_CYC-1:0]  kind_list,
   input  logic [AW*MAX_CYC-1:0] addr_list,
   input  logic [DW*MAX_CYC-1:0] wdata_list,
   input  logic [DW-1:0]         ad_in,
   output logic [DW-1:0]         ad_out,
   output logic                  ad_oe,
   output logic [AW-DW-1:0]      a_hi,
   output logic                  ale,
   output logic                  io_m,
   output logic                  s1,
   output logic                  s0,
   output logic                  rd_n,
   output logic                  wr_n,
   output logic [DW-1:0]         rdata,
   output logic                  rd_valid,
   output logic                  busy,
   output logic                  done,
   output logic [TW-1:0]         t_total
);

   generate
      if (MAX_CYC < 1 || MAX_CYC > 7) begin : g_bad_depth
         $error("mcyc_seq: MAX_CYC must lie in 1..7");
      end
      if (AW != 2 * DW) begin : g_bad_width
         $error("mcyc_seq: AW must be twice DW");
      end
   endgenerate

   logic [2:0]    kind_q [MAX_CYC];
   logic [AW-1:0] addr_q [MAX_CYC];
   logic [DW-1:0] wd_q   [MAX_CYC];

   logic           load;
   logic [NCW-1:0] idx;
   logic [1:0]     tst;
   mc_kind_e       cur_kind;
   logic [AW-1:0]  cur_addr;
   logic [DW-1:0]  cur_wd;

   // list registers, one slot per entry
   generate
      for (genvar g = 0; g < MAX_CYC; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kind_q[g] <= '0;
               addr_q[g] <= '0;
               wd_q[g]   <= '0;
            end else if (load) begin
               kind_q[g] <= kind_list[3*g +: 3];
               addr_q[g] <= addr_list[AW*g +: AW];
               wd_q[g]   <= wdata_list[DW*g +: DW];
            end
         end
      end
   endgenerate

   // entry 0 is always an opcode fetch
   assign cur_kind = (idx == '0) ? MC_OPF : norm_kind(kind_q[idx]);
   assign cur_addr = addr_q[idx];
   assign cur_wd   = wd_q[idx];

   mcyc_tstate_ctr #(
      .MAX_CYC (MAX_CYC),
      .NCW     (NCW),
      .TW      (TW)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .n_cyc    (n_cyc),
      .cur_kind (cur_kind),
      .load     (load),
      .busy     (busy),
      .idx      (idx),
      .tst      (tst),
      .done     (done),
      .t_total  (t_total)
   );

   mcyc_bus_drv #(
      .AW             (AW),
      .DW             (DW),
      .IO_ADDR_MIRROR (IO_ADDR_MIRROR)
   ) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy),
      .tst    (tst),
      .kind   (cur_kind),
      .addr   (cur_addr),
      .wdata  (cur_wd),
      .ad_out (ad_out),
      .ad_oe  (ad_oe),
      .a_hi   (a_hi),
      .ale    (ale),
      .io_m   (io_m),
      .s1     (s1),
      .s0     (s0),
      .rd_n   (rd_n),
      .wr_n   (wr_n)
   );

   mcyc_rd_capture #(
      .DW (DW)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .tst      (tst),
      .kind     (cur_kind),
      .ad_in    (ad_in),
      .rdata    (rdata),
      .rd_valid (rd_valid)
   );

   // R9
   first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (io_m == 1'b0 && s1 && s0 && ale));

endmodule

// File: tb/sim_mcyc_seq.sv
module sim_mcyc_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [2:0]  n_cyc;
   logic [14:0] kind_list;
   logic [79:0] addr_list;
   logic [39:0] wdata_list;
   logic [7:0]  ad_in;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  a_hi;
   logic        ale, io_m, s1, s0, rd_n, wr_n;
   logic [7:0]  rdata;
   logic        rd_valid, busy, done;
   logic [4:0]  t_total;

   int vecs = 0;
   int errs = 0;
   bit pend_rv = 0;
   int pend_data = 0;

   always #5 clk = ~clk;

   mcyc_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .n_cyc(n_cyc),
      .kind_list(kind_list), .addr_list(addr_list), .wdata_list(wdata_list),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
      .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
      .rdata(rdata), .rd_valid(rd_valid), .busy(busy), .done(done),
      .t_total(t_total)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // read-valid bookkeeping shared by every sampled clock (R8)
   task automatic chk_rv();
      chk("R8", "rd_valid", {31'd0, rd_valid}, {31'd0, pend_rv});
      if (pend_rv) chk("R8", "rdata", {24'd0, rdata}, pend_data);
      pend_rv = 0;
   endtask

   task automatic chk_idle(input string tag);
      chk(tag, "ale", {31'd0, ale}, 0);
      chk(tag, "status", {29'd0, io_m, s1, s0}, 0);
      chk(tag, "rd_n", {31'd0, rd_n}, 1);
      chk(tag, "wr_n", {31'd0, wr_n}, 1);
      chk(tag, "ad_oe", {31'd0, ad_oe}, 0);
      chk(tag, "a_hi", {24'd0, a_hi}, 0);
      chk(tag, "busy", {31'd0, busy}, 0);
   endtask

   function automatic int rd_byte(input int c, input int a);
      return ((a & 8'hFF) ^ 8'h5A ^ (c * 17)) & 8'hFF;
   endfunction

   // drives one instruction and checks every clock against the reference
   task automatic run_instr(input int n_req, input int kinds[5],
                            input int addrs[5], input int wds[5],
                            input bit poke_start);
      int n_eff;
      int total;
      for (int i = 0; i < 5; i++) begin
         kind_list[3*i +: 3]   = kinds[i][2:0];
         addr_list[16*i +: 16] = addrs[i][15:0];
         wdata_list[8*i +: 8]  = wds[i][7:0];
      end
      n_cyc = n_req[2:0];
      n_eff = (n_req == 0) ? 1 : ((n_req > 5) ? 5 : n_req);
      total = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < n_eff; c++) begin
         int k, len, stv, ahi, lo;
         bit rd, wr, io;
         k   = (c == 0) ? 0 : ((kinds[c] > 4) ? 1 : kinds[c]);
         len = (k == 0) ? 4 : 3;
         rd  = (k == 0 || k == 1 || k == 3);
         wr  = (k == 2 || k == 4);
         io  = (k >= 3);
         case (k)
            0: stv = 3'b011;
            1: stv = 3'b010;
            2: stv = 3'b001;
            3: stv = 3'b110;
            default: stv = 3'b101;
         endcase
         lo  = addrs[c] & 8'hFF;
         ahi = io ? lo : ((addrs[c] >> 8) & 8'hFF);
         for (int t = 0; t < len; t++) begin
            bit strobe;
            strobe = (t == 1 || t == 2);
            if (t == 0) ad_in = 8'hEE;
            if (t == 2 && rd) ad_in = rd_byte(c, addrs[c]);
            chk("R4", "ale", {31'd0, ale}, (t == 0));
            chk("R3", "status", {29'd0, io_m, s1, s0}, stv);
            chk("R6", "rd_n", {31'd0, rd_n}, !(rd && strobe));
            chk("R6", "wr_n", {31'd0, wr_n}, !(wr && strobe));
            chk("R5", "ad_oe", {31'd0, ad_oe}, (t == 0) || (wr && strobe));
            if (t == 0) chk("R7", "ad_out addr", {24'd0, ad_out}, lo);
            else if (wr && strobe) chk("R5", "ad_out data", {24'd0, ad_out}, wds[c] & 8'hFF);
            chk("R7", "a_hi", {24'd0, a_hi}, ahi);
            chk("R2", "busy", {31'd0, busy}, 1);
            chk("R10", "done low", {31'd0, done}, 0);
            chk_rv();
            if (t == 2 && rd) begin
               pend_rv   = 1;
               pend_data = rd_byte(c, addrs[c]);
            end
            total++;
            // R11: start raised during T2 of the first cycle
            start = (poke_start && c == 0 && t == 1);
            @(negedge clk);
         end
      end
      start = 1'b0;
      chk("R10", "done", {31'd0, done}, 1);
      chk("R10", "t_total", {27'd0, t_total}, total);
      chk_idle("R1");
      chk_rv();
      @(negedge clk);
      chk("R10", "done drop", {31'd0, done}, 0);
      chk("R10", "t_total hold", {27'd0, t_total}, total);
      chk_idle("R1");
      chk_rv();
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; n_cyc = '0;
      kind_list = '0; addr_list = '0; wdata_list = '0; ad_in = 8'hEE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_idle("R1");
      chk("R1", "done", {31'd0, done}, 0);
      chk("R1", "rd_valid", {31'd0, rd_valid}, 0);
      // R2 R10: fetch + memory read, 7 T-states
      run_instr(2, '{0, 1, 0, 0, 0}, '{16'h2000, 16'h2001, 0, 0, 0}, '{0, 0, 0, 0, 0}, 0);
      // R3 R7: fetch, read, I/O write, 10 T-states
      run_instr(3, '{0, 1, 4, 0, 0}, '{16'h2100, 16'h2101, 16'h0007, 0, 0}, '{0, 0, 8'h3C, 0, 0}, 0);
      // R5 R6: memory writes and an I/O read
      run_instr(5, '{0, 1, 2, 2, 3}, '{16'h4000, 16'h4001, 16'h8123, 16'h8124, 16'h00F2},
                '{0, 0, 8'hA5, 8'h5A, 0}, 0);
      // R9: entry 0 kind ignored, code 6 acts as memory read
      run_instr(2, '{2, 6, 0, 0, 0}, '{16'h1234, 16'hBEEF, 0, 0, 0}, '{8'h77, 8'h66, 0, 0, 0}, 0);
      // R9: count 0 runs one cycle
      run_instr(0, '{0, 2, 0, 0, 0}, '{16'h0F0F, 0, 0, 0, 0}, '{0, 0, 0, 0, 0}, 0);
      // R9: count 7 runs five cycles
      run_instr(7, '{0, 4, 3, 2, 1}, '{16'hC000, 16'h0044, 16'h0055, 16'hD00D, 16'hE00E},
                '{0, 8'h11, 0, 8'h22, 0}, 0);
      // R11: start pulse while busy has no effect
      run_instr(3, '{0, 2, 3, 0, 0}, '{16'h3000, 16'h3456, 16'h0099, 0, 0}, '{0, 8'hC3, 0, 0, 0}, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule